// File: doc/BRIEF.md
# PLL Bypass and Relock Sequencer

This block is the control logic for a clock-generation unit built around a phase-locked loop. Software programs a control register and a multiplier register over a simple register bus. When a new multiplier value arrives, the block runs the whole retune in hardware. It switches the clock output onto the reference path and waits a short settle time. It then puts the loop into reset and loads the new multiplier. After a hold time it releases reset, waits for the lock time, and only then selects the loop output again. Software does not have to time any step itself.

All waits are counted in reference-clock cycles, signalled by a one-cycle-wide enable input. The analog loop is not modelled. Its lock behaviour stands behind a modelled lock flag that is set when the lock wait completes. The bypass-select output is meant to steer a glitch-free clock mux outside the block. The power-down and clock-source-mode bits are stored and read back only.

Top module: `pll_relock_seq`

## Requirements
- R1: After reset the register reads are: control = 0x0009 (enable bit 0 and active-low reset bit 3 set), multiplier = INIT_MULT, status = 0. The outputs are bypass_sel = 0, pll_rst_n = 1 and pll_locked = 1.
- R2: In idle, a multiplier write (bus address 1) with a value in [MULT_MIN, MULT_MAX] makes the status busy bit (bit 0 of address 2) read 1 from the next cycle. From the same cycle bypass_sel = 1, and control bits 0 (enable) and 5 (enable-source) read 0.
- R3: During the bypass settle, pll_rst_n stays 1 and the applied multiplier is unchanged. On the BYP_TICKS-th cycle with ref_en high after the write, pll_rst_n drops, control bits 3 and 4 clear, and the new multiplier is applied. Cycles with ref_en low are not counted.
- R4: pll_rst_n stays low for exactly RST_TICKS ref_en cycles and then returns to 1. pll_locked is 0 from reset entry until the lock wait ends.
- R5: LOCK_TICKS ref_en cycles after reset release, the enable bit is set and busy, bypass_sel and pll_locked go to 0, 0 and 1. The control register then reads 0x0009 again.
- R6: rate_factor equals multiplier+1 when DOUBLE_MULT = 0, and 2×multiplier when DOUBLE_MULT = 1.
- R7: A multiplier write outside [MULT_MIN, MULT_MAX] is ignored: the multiplier read does not change and no sequence starts. Such a write sets status bit 1, which stays set until reset.
- R8: A valid multiplier write during the bypass settle does not restart the count, and it is the value applied at that reset entry. A valid write during the reset hold or the lock wait runs one more full bypass, reset and lock pass after the current lock wait. In that case busy and bypass_sel stay 1 between the passes and the second value is applied.
- R9: Control writes (address 0) store only bits 0, 1, 3, 4, 5 and 8 (all other bits read 0), and they are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle pulse per reference-clock cycle; paces all waits |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 multiplier, 2 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| bypass_sel | output | 1 | 1 selects the reference path on the external clock mux |
| pll_rst_n | output | 1 | Active-low reset to the loop |
| pll_locked | output | 1 | Modelled lock flag |
| mult_applied | output | MW | Multiplier currently applied to the loop |
| rate_factor | output | MW+1 | Output-to-input frequency ratio |

## Verification
The bench sweeps every multiplier code of a 4-bit configuration under three ref_en cadences. It tracks the phase boundaries cycle by cycle from its own count of reference ticks, so a design that counted plain clocks or was off by one at a phase edge would drop or raise pll_rst_n a cycle early or late. Writes that land mid-sequence are aimed at the settle phase and at the lock phase. A design that restarted the wait would finish late. One that dropped the late value would leave the old multiplier applied. One that briefly left bypass between the two passes would show bypass_sel low. Out-of-range codes at both ends of the range are checked to leave the multiplier untouched and to latch the error bit. A control write during a sequence is checked to leave the register unchanged.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_BYP, PH_RST, PH_LOCK} phase_t;

  // control register bit positions
  localparam int CB_EN    = 0;
  localparam int CB_PWRDN = 1;
  localparam int CB_RSTN  = 3;
  localparam int CB_DIS   = 4;
  localparam int CB_SRC   = 5;
  localparam int CB_MODE  = 8;

  localparam logic [15:0] CTRL_MASK = 16'h013B;
  localparam logic [15:0] CTRL_INIT = 16'h0009;

  // frequency ratio for a multiplier code
  function automatic logic [16:0] calc_rate(input logic [15:0] m, input logic dbl);
    if (dbl) return {m, 1'b0};
    else     return {1'b0, m} + 17'd1;
  endfunction

  function automatic logic code_ok(input logic [15:0] v, input logic [15:0] lo,
                                   input logic [15:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  assign done = tick && !clr && (cnt_q == limit - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr || done)  cnt_q <= '0;
    else if (tick)         cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int TW         = 4,
  parameter int BYP_TICKS  = 4,
  parameter int RST_TICKS  = 25,
  parameter int LOCK_TICKS = 500
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ref_en,
  input  logic   start,
  input  logic   again,
  output phase_t phase,
  output logic   ev_byp,
  output logic   ev_rst,
  output logic   ev_rel,
  output logic   ev_lock,
  output logic   ev_done
);
  phase_t        ph_q, ph_d;
  logic [TW-1:0] limit;
  logic          tdone;

  always_comb begin
    case (ph_q)
      PH_BYP:  limit = TW'(BYP_TICKS);
      PH_RST:  limit = TW'(RST_TICKS);
      PH_LOCK: limit = TW'(LOCK_TICKS);
      default: limit = TW'(1);
    endcase
  end

  pll_seq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(ph_q == PH_IDLE), .tick(ref_en),
    .limit(limit), .done(tdone)
  );

  assign ev_rst  = (ph_q == PH_BYP)  && tdone;
  assign ev_rel  = (ph_q == PH_RST)  && tdone;
  assign ev_lock = (ph_q == PH_LOCK) && tdone;
  assign ev_done = ev_lock && !again;
  assign ev_byp  = ((ph_q == PH_IDLE) && start) || (ev_lock && again);

  always_comb begin
    ph_d = ph_q;
    if (ev_byp)       ph_d = PH_BYP;
    else if (ev_rst)  ph_d = PH_RST;
    else if (ev_rel)  ph_d = PH_LOCK;
    else if (ev_done) ph_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;
endmodule

// File: rtl/pll_relock_seq.sv
module pll_relock_seq
  import pll_seq_pkg::*;
#(
  parameter int MW          = 5,
  parameter int MULT_MIN    = 1,
  parameter int MULT_MAX    = 24,
  parameter int INIT_MULT   = 7,
  parameter int BYP_TICKS   = 4,
  parameter int RST_TICKS   = 25,
  parameter int LOCK_TICKS  = 500,
  parameter bit DOUBLE_MULT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_en,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          bypass_sel,
  output logic          pll_rst_n,
  output logic          pll_locked,
  output logic [MW-1:0] mult_applied,
  output logic [MW:0]   rate_factor
);
  localparam int MAXT_BR = (BYP_TICKS > RST_TICKS) ? BYP_TICKS : RST_TICKS;
  localparam int MAXT    = (MAXT_BR > LOCK_TICKS) ? MAXT_BR : LOCK_TICKS;
  localparam int TW      = $clog2(MAXT + 1);

  phase_t        phase;
  logic          ev_byp, ev_rst, ev_rel, ev_lock, ev_done;
  logic [15:0]   ctrl_q;
  logic [MW-1:0] mult_q, pend_q, new_mult;
  logic          again_q, err_q, locked_q;
  logic          busy, in_pass, ctl_wr, mul_wr, good_wr, bad_wr, start, again_now;
  logic [16:0]   rate_w;

  // named events for the checker
  assign busy      = (phase != PH_IDLE);
  assign in_pass   = (phase == PH_RST) || (phase == PH_LOCK);
  assign ctl_wr    = bus_wr && (bus_addr == 2'd0);
  assign mul_wr    = bus_wr && (bus_addr == 2'd1);
  assign good_wr   = mul_wr &&  code_ok(bus_wdata, 16'(MULT_MIN), 16'(MULT_MAX));
  assign bad_wr    = mul_wr && !code_ok(bus_wdata, 16'(MULT_MIN), 16'(MULT_MAX));
  assign start     = good_wr && !busy;
  assign again_now = again_q || (good_wr && in_pass);
  assign new_mult  = good_wr ? bus_wdata[MW-1:0] : pend_q;

  pll_seq_fsm #(
    .TW(TW), .BYP_TICKS(BYP_TICKS), .RST_TICKS(RST_TICKS), .LOCK_TICKS(LOCK_TICKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .start(start), .again(again_now),
    .phase(phase), .ev_byp(ev_byp), .ev_rst(ev_rst), .ev_rel(ev_rel),
    .ev_lock(ev_lock), .ev_done(ev_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= MW'(INIT_MULT);
      mult_q   <= MW'(INIT_MULT);
      again_q  <= 1'b0;
      err_q    <= 1'b0;
      locked_q <= 1'b1;
    end else begin
      if (good_wr) pend_q <= bus_wdata[MW-1:0];
      if (ev_rst)  mult_q <= new_mult;
      if (ev_rst)                     again_q <= 1'b0;
      else if (good_wr && in_pass)    again_q <= 1'b1;
      err_q <= err_q | bad_wr;
      if (ev_rst)       locked_q <= 1'b0;
      else if (ev_lock) locked_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_INIT;
    end else if (ctl_wr && !busy) begin
      ctrl_q <= bus_wdata & CTRL_MASK;
    end else begin
      if (ev_byp) begin
        ctrl_q[CB_EN]  <= 1'b0;
        ctrl_q[CB_SRC] <= 1'b0;
      end
      if (ev_rst) begin
        ctrl_q[CB_RSTN] <= 1'b0;
        ctrl_q[CB_DIS]  <= 1'b0;
      end
      if (ev_rel)  ctrl_q[CB_RSTN] <= 1'b1;
      if (ev_done) ctrl_q[CB_EN]   <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = ctrl_q;
      2'd1:    bus_rdata = 16'(mult_q);
      2'd2:    bus_rdata = {14'd0, err_q, busy};
      default: bus_rdata = 16'd0;
    endcase
  end

  assign rate_w       = calc_rate(16'(mult_q), DOUBLE_MULT);
  assign rate_factor  = rate_w[MW:0];
  assign bypass_sel   = !ctrl_q[CB_EN];
  assign pll_rst_n    = ctrl_q[CB_RSTN];
  assign pll_locked   = locked_q;
  assign mult_applied = mult_q;
endmodule

// File: rtl/pll_relock_chk.sv
module pll_relock_chk #(
  parameter int MW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          bypass_sel,
  input logic          pll_rst_n,
  input logic          pll_locked,
  input logic          err_q,
  input logic          bad_wr,
  input logic          ctl_wr,
  input logic [15:0]   ctrl_q,
  input logic [MW-1:0] mult_applied
);
  assert_busy_bypassed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bypass_sel);

  assert_reset_in_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst_n) |-> bypass_sel);

  assert_mult_moves_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mult_applied) |-> !pll_rst_n);

  assert_unlocked_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_rst_n |-> !pll_locked);

  assert_exit_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (pll_locked && !bypass_sel && pll_rst_n));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  assert_bad_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_wr && !busy) |=> (!busy && $stable(mult_applied)));

  assert_ctl_locked_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_wr) |=> $stable({ctrl_q[8], ctrl_q[1]}));
endmodule

bind pll_relock_seq pll_relock_chk #(.MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bypass_sel(bypass_sel),
  .pll_rst_n(pll_rst_n), .pll_locked(pll_locked), .err_q(err_q),
  .bad_wr(bad_wr), .ctl_wr(ctl_wr), .ctrl_q(ctrl_q), .mult_applied(mult_applied)
);

// File: tb/sim_pll_relock_seq.sv
module sim_pll_relock_seq;
  localparam int MW = 4, MMIN = 2, MMAX = 12, INIT = 5;
  localparam int B = 3, R = 2, L = 4, T = B + R + L;

  logic clk = 1'b0, rst_n = 1'b0, ref_en = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] rdata0, rdata1;
  logic byp0, rstn0, lock0, byp1, rstn1, lock1;
  logic [MW-1:0] ma0, ma1;
  logic [MW:0] rf0, rf1;

  int checks = 0, errors = 0, cyc = 0, mode = 0, k = 0;
  bit tick_seen;

  always #4 clk = ~clk;

  pll_relock_seq #(.MW(MW), .MULT_MIN(MMIN), .MULT_MAX(MMAX), .INIT_MULT(INIT),
    .BYP_TICKS(B), .RST_TICKS(R), .LOCK_TICKS(L), .DOUBLE_MULT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata0), .bypass_sel(byp0), .pll_rst_n(rstn0),
    .pll_locked(lock0), .mult_applied(ma0), .rate_factor(rf0));

  pll_relock_seq #(.MW(MW), .MULT_MIN(MMIN), .MULT_MAX(MMAX), .INIT_MULT(INIT),
    .BYP_TICKS(B), .RST_TICKS(R), .LOCK_TICKS(L), .DOUBLE_MULT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata1), .bypass_sel(byp1), .pll_rst_n(rstn1),
    .pll_locked(lock1), .mult_applied(ma1), .rate_factor(rf1));

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic step();
    ref_en = (mode == 0) || ((cyc % (mode + 1)) == 0);
    @(posedge clk);
    tick_seen = ref_en;
    #1;
    cyc++;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(rdata0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  // follows one bypass/reset/lock pass tick by tick from the start edge
  task automatic run_pass(input int late_k, input logic [1:0] late_a,
                          input logic [15:0] late_d, input bit more);
    bit sent = 0;
    int st;
    k = 0;
    while (k < T) begin
      if (k == late_k && !sent) begin
        bus_addr = late_a; bus_wdata = late_d; bus_wr = 1'b1; sent = 1;
      end
      step();
      bus_wr = 1'b0;
      if (tick_seen) k++;
      if (k < T) begin
        chk("R2 bypass held", byp0, 1);
        chk((k >= B && k < B + R) ? "R3 reset low" : "R4 reset high",
            rstn0, !(k >= B && k < B + R));
        chk("R4 locked flag", lock0, !(k >= B));
      end
    end
    rd(2'd2, st);
    chk("R5/R8 busy at pass end", st & 1, more);
    chk("R5/R8 bypass at pass end", byp0, more);
    chk("R5 locked at pass end", lock0, 1);
    chk("R5 reset high at pass end", rstn0, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int v, st, cur;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v);  chk("R1 ctrl reset", v, 16'h0009);
    rd(2'd1, v);  chk("R1 mult reset", v, INIT);
    rd(2'd2, v);  chk("R1 status reset", v, 0);
    chk("R1 bypass_sel", byp0, 0);
    chk("R1 pll_rst_n", rstn0, 1);
    chk("R1 pll_locked", lock0, 1);
    chk("R6 rate reset", rf0, INIT + 1);
    chk("R6 rate reset alt", rf1, 2 * INIT);

    // R9 idle control write keeps only defined bits
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R9 ctrl mask", v, 16'h013B);
    wr(2'd0, 16'h0009);
    rd(2'd0, v); chk("R9 ctrl restore", v, 16'h0009);

    // R6/R7 sweep every code, three ref_en cadences
    cur = INIT;
    for (int m = 0; m < 16; m++) begin
      mode = m % 3;
      wr(2'd1, 16'(m));
      if (m < MMIN || m > MMAX) begin
        rd(2'd2, st);
        chk("R7 no start", st & 1, 0);
        chk("R7 err set", (st >> 1) & 1, 1);
        rd(2'd1, v); chk("R7 mult kept", v, cur);
        step();
        chk("R7 still idle bypass", byp0, 0);
      end else begin
        rd(2'd2, st); chk("R2 busy", st & 1, 1);
        chk("R2 bypass", byp0, 1);
        rd(2'd0, v); chk("R2 en/src clear", v & 16'h0021, 0);
        run_pass(-1, 2'd0, 16'd0, 1'b0);
        cur = m;
        rd(2'd1, v); chk("R3 mult applied", v, m);
        rd(2'd0, v); chk("R5 ctrl restored", v, 16'h0009);
        chk("R6 rate", rf0, m + 1);
        chk("R6 rate alt", rf1, 2 * m);
        rd(2'd2, st); chk("R7 err sticky", (st >> 1) & 1, (m > 0) ? 1 : 0);
      end
    end

    // R9 control write while busy is ignored
    mode = 1;
    wr(2'd1, 16'd7);
    run_pass(1, 2'd0, 16'h0102, 1'b0);
    rd(2'd0, v); chk("R9 busy write ignored", v, 16'h0009);

    // R8 late write during settle: same timing, new value applied
    mode = 0;
    wr(2'd1, 16'd4);
    run_pass(1, 2'd1, 16'd9, 1'b0);
    rd(2'd1, v); chk("R8 settle write applied", v, 9);

    // R8 late write during lock wait: second pass
    mode = 2;
    wr(2'd1, 16'd6);
    run_pass(B + R, 2'd1, 16'd10, 1'b1);
    rd(2'd1, v); chk("R8 first value applied", v, 6);
    run_pass(-1, 2'd0, 16'd0, 1'b0);
    rd(2'd1, v); chk("R8 second value applied", v, 10);
    chk("R8 rate after second pass", rf0, 11);

    // R7 out-of-range late write ignored during a pass
    mode = 0;
    wr(2'd1, 16'd3);
    run_pass(2, 2'd1, 16'd15, 1'b0);
    rd(2'd1, v); chk("R7 late bad ignored", v, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule